// File: doc/BRIEF.md
# Serial Port FIFO Control Unit

This block sits between a host register interface and the byte paths of a serial port. It holds a receive queue and a transmit queue, each sixteen bytes deep. It also decodes one write-only control byte, which does four things: switches queueing on or off, picks the receive threshold, and requests that either queue be emptied. When the receive queue holds at least the threshold number of bytes, the block raises an interrupt line toward the host.

The control byte and the interrupt identification byte share one host address. A write lands in the control byte, and a read returns the identification byte. That byte shows whether queueing is on and whether the receive-threshold interrupt is pending. The serial side pushes received bytes and pops bytes to transmit. The host side pops received bytes and pushes bytes to send. A power-state return to the active state clears the control byte, just as reset does.

Top module: `sfc_top`

## Requirements
- R1: After reset the control fields are zero, both queues are empty, `rx_irq` is low, `fifo_mode` and `aux_mode` are low, and a read at address 2 returns 0x01.
- R2: A write with `host_addr` equal to 2 loads the control byte. A write to any other address changes no control field.
- R3: With `fifo_mode` high, control bits 7:6 select the receive threshold: 00 selects 1 byte, 01 selects 4, 10 selects 8 and 11 selects 14. `rx_irq` is high exactly while the receive count is at or above that threshold.
- R4: Writing 1 to control bit 2 empties the transmit queue at the clock edge after the write. The request clears itself, so bytes pushed afterwards are kept.
- R5: Writing 1 to control bit 1 empties the receive queue at the clock edge after the write. The request clears itself, so bytes pushed afterwards are kept.
- R6: Control bit 0 is `fifo_mode`. A write that changes bit 0, in either direction, empties both queues at the next edge. A write that keeps the same value of bit 0 empties neither queue.
- R7: Control bit 3 is stored and shown on `aux_mode`, and it has no other effect. Bits 5:4 are ignored.
- R8: Each queue holds 16 bytes in first-in first-out order. A push into a full queue and a pop from an empty queue are both ignored. Either event sets that queue's error flag, which stays set until reset.
- R9: With `fifo_mode` low, each queue holds at most one byte, and `rx_irq` is high whenever the receive queue holds a byte, whatever the threshold code.
- R10: A read at address 2 returns bits 7:6 = 11 when `fifo_mode` is high and 00 when it is low, bits 5:4 = 00, and a low nibble of 4 while `rx_irq` is high or 1 otherwise. A read at any other address returns 0x00.
- R11: A push presented in the same cycle that a queue is being emptied is discarded.
- R12: A `pwr_wake` pulse clears every control field and empties both queues at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_wake | input | 1 | Pulse on return to the active power state |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (interrupt identification at address 2) |
| fifo_mode | output | 1 | Queueing enabled |
| aux_mode | output | 1 | Stored control bit 3 |
| rx_push | input | 1 | Serial side delivers a received byte |
| rx_data | input | 8 | Received byte |
| rx_pop | input | 1 | Host takes a received byte |
| rx_dout | output | 8 | Head of the receive queue |
| rx_count | output | 5 | Receive queue occupancy |
| rx_err | output | 1 | Sticky receive overflow or underflow flag |
| rx_irq | output | 1 | Receive-threshold interrupt |
| tx_push | input | 1 | Host writes a byte to send |
| tx_data | input | 8 | Byte to send |
| tx_pop | input | 1 | Serial side takes a byte to send |
| tx_dout | output | 8 | Head of the transmit queue |
| tx_count | output | 5 | Transmit queue occupancy |
| tx_err | output | 1 | Sticky transmit overflow or underflow flag |

## Verification
The assertions assume that `pwr_wake` and the host write strobe are single-cycle pulses. They also assume that nobody pops a queue in the cycle it is being emptied, because the ignored-pop and self-clear properties only make sense under that rule. The stimulus drives each strobe for exactly one clock. It issues pops only when no emptying request is pending. It keeps `host_addr` at 2 except during the single write and read that test other addresses.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned CTRL_ADDR = 2;

    // Fields of the write-only control byte
    typedef struct packed {
        logic [1:0] trig;
        logic       aux;
        logic       en;
        logic       rx_flush;
        logic       tx_flush;
    } ctrl_t;

    // Non-linear threshold map for the receive interrupt
    function automatic logic [7:0] trig_level(input logic [1:0] code);
        case (code)
            2'b00:   return 8'd1;
            2'b01:   return 8'd4;
            2'b10:   return 8'd8;
            default: return 8'd14;
        endcase
    endfunction

endpackage

// File: rtl/sfc_ctrl_reg.sv
module sfc_ctrl_reg
    import sfc_pkg::*;
#(
    parameter int unsigned AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wake,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [1:0]        trig_code,
    output logic              fifo_en,
    output logic              aux,
    output logic              rx_flush,
    output logic              tx_flush
);

    ctrl_t ctrl_d, ctrl_q;
    logic  sel;

    assign sel = wr && (addr == AW'(CTRL_ADDR));

    always_comb begin
        ctrl_d          = ctrl_q;
        ctrl_d.rx_flush = 1'b0;
        ctrl_d.tx_flush = 1'b0;
        if (wake) begin
            ctrl_d          = '0;
            ctrl_d.rx_flush = 1'b1;
            ctrl_d.tx_flush = 1'b1;
        end else if (sel) begin
            ctrl_d.trig = wdata[7:6];
            ctrl_d.aux  = wdata[3];
            ctrl_d.en   = wdata[0];
            if (wdata[0] != ctrl_q.en) begin
                ctrl_d.rx_flush = 1'b1;
                ctrl_d.tx_flush = 1'b1;
            end
            if (wdata[1]) ctrl_d.rx_flush = 1'b1;
            if (wdata[2]) ctrl_d.tx_flush = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign trig_code = ctrl_q.trig;
    assign fifo_en   = ctrl_q.en;
    assign aux       = ctrl_q.aux;
    assign rx_flush  = ctrl_q.rx_flush;
    assign tx_flush  = ctrl_q.tx_flush;

    // R4: transmit flush request lasts one cycle unless renewed
    a_r4_tx_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !(wake || (sel && (wdata[2] || (wdata[0] != fifo_en)))) |=> !tx_flush);

    // R5: receive flush request lasts one cycle unless renewed
    a_r5_rx_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !(wake || (sel && (wdata[1] || (wdata[0] != fifo_en)))) |=> !rx_flush);

    // R6: a change of the enable bit requests both flushes
    a_r6_toggle_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake && sel && (wdata[0] != fifo_en)) |=> (rx_flush && tx_flush));

    // R7: reserved bits do not block the load of the enable bit
    a_r7_rsv_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake && sel && (wdata[5:4] != 2'b00)) |=> (fifo_en == $past(wdata[0])));

    // R12: wake clears the fields and requests both flushes
    a_r12_wake_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> (!fifo_en && !aux && trig_code == 2'b00 && rx_flush && tx_flush));

endmodule

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          single,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count,
    output logic          err
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
        logic                     err;
    } fifo_t;

    fifo_t         st_d, st_q;
    logic [CW-1:0] cap;
    logic          full, empty, do_push, do_pop;

    assign cap     = single ? CW'(1) : CW'(DEPTH);
    assign full    = (st_q.cnt >= cap);
    assign empty   = (st_q.cnt == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if ((push && full) || (pop && empty)) st_d.err = 1'b1;
            if (do_push) begin
                st_d.mem[st_q.wp] = din;
                st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
            end
            if (do_pop) begin
                st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
            end
            st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout  = st_q.mem[st_q.rp];
    assign count = st_q.cnt;
    assign err   = st_q.err;

    // R8: a push into a full queue leaves the count unchanged and flags it
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> ($stable(count) && err));

    // R8: the error flag is sticky
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R8: occupancy never exceeds the depth
    a_r8_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R11: a flush cycle leaves the queue empty, whatever was pushed
    a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));

endmodule

// File: rtl/sfc_top.sv
module sfc_top
    import sfc_pkg::*;
#(
    parameter int unsigned AW    = 3,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_wake,
    input  logic              host_wr,
    input  logic [AW-1:0]     host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              fifo_mode,
    output logic              aux_mode,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_pop,
    output logic [BYTE_W-1:0] rx_dout,
    output logic [CW-1:0]     rx_count,
    output logic              rx_err,
    output logic              rx_irq,
    input  logic              tx_push,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_pop,
    output logic [BYTE_W-1:0] tx_dout,
    output logic [CW-1:0]     tx_count,
    output logic              tx_err
);

    logic [1:0] trig_code;
    logic       rx_flush, tx_flush;
    logic [7:0] level;

    sfc_ctrl_reg #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake      (pwr_wake),
        .wr        (host_wr),
        .addr      (host_addr),
        .wdata     (host_wdata),
        .trig_code (trig_code),
        .fifo_en   (fifo_mode),
        .aux       (aux_mode),
        .rx_flush  (rx_flush),
        .tx_flush  (tx_flush)
    );

    sfc_fifo #(.DW(BYTE_W), .DEPTH(DEPTH)) u_rx (
        .clk (clk), .rst_n (rst_n), .flush (rx_flush), .single (!fifo_mode),
        .push (rx_push), .din (rx_data), .pop (rx_pop),
        .dout (rx_dout), .count (rx_count), .err (rx_err)
    );

    sfc_fifo #(.DW(BYTE_W), .DEPTH(DEPTH)) u_tx (
        .clk (clk), .rst_n (rst_n), .flush (tx_flush), .single (!fifo_mode),
        .push (tx_push), .din (tx_data), .pop (tx_pop),
        .dout (tx_dout), .count (tx_count), .err (tx_err)
    );

    assign level  = fifo_mode ? trig_level(trig_code) : 8'd1;
    assign rx_irq = (8'(rx_count) >= level);

    always_comb begin
        host_rdata = '0;
        if (host_addr == AW'(CTRL_ADDR)) begin
            host_rdata[7:6] = fifo_mode ? 2'b11 : 2'b00;
            host_rdata[3:0] = rx_irq ? 4'h4 : 4'h1;
        end
    end

    // R3: the interrupt never fires on an empty receive queue
    a_r3_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (rx_count != '0));

    // R3: at fourteen bytes every threshold has been reached
    a_r3_top_level_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && rx_count >= CW'(14)) |-> rx_irq);

    // R9: one held byte always interrupts when queueing is off
    a_r9_single_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_mode && rx_count != '0) |-> rx_irq);

endmodule

// File: tb/sfc_top_bench.sv
module sfc_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_wake = 1'b0;
    logic       host_wr = 1'b0;
    logic [2:0] host_addr = 3'd2;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       fifo_mode, aux_mode;
    logic       rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
    logic [7:0] rx_data = '0, tx_data = '0;
    logic [7:0] rx_dout, tx_dout;
    logic [4:0] rx_count, tx_count;
    logic       rx_err, tx_err, rx_irq;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;
    logic [7:0] rxq[$];
    logic [7:0] txq[$];

    always #10 clk = ~clk;

    sfc_top u_sfc_top (
        .clk(clk), .rst_n(rst_n), .pwr_wake(pwr_wake),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .fifo_mode(fifo_mode), .aux_mode(aux_mode),
        .rx_push(rx_push), .rx_data(rx_data), .rx_pop(rx_pop),
        .rx_dout(rx_dout), .rx_count(rx_count), .rx_err(rx_err), .rx_irq(rx_irq),
        .tx_push(tx_push), .tx_data(tx_data), .tx_pop(tx_pop),
        .tx_dout(tx_dout), .tx_count(tx_count), .tx_err(tx_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr_at(input logic [2:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        tick();
        host_wr = 1'b0; host_addr = 3'd2;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_at(3'd2, d);
    endtask

    // Driver: pushes expected bytes into the scoreboard queues
    task automatic push_rx(input logic [7:0] b, input bit keep);
        rx_push = 1'b1; rx_data = b;
        tick();
        rx_push = 1'b0;
        if (keep) rxq.push_back(b);
    endtask

    task automatic push_tx(input logic [7:0] b, input bit keep);
        tx_push = 1'b1; tx_data = b;
        tick();
        tx_push = 1'b0;
        if (keep) txq.push_back(b);
    endtask

    task automatic pop_rx();
        rx_pop = 1'b1; tick(); rx_pop = 1'b0;
    endtask

    task automatic pop_tx();
        tx_pop = 1'b1; tick(); tx_pop = 1'b0;
    endtask

    // Monitor: compares each popped head with the scoreboard (R8 ordering)
    always @(negedge clk) begin
        if (rst_n && rx_pop && rx_count != 0) begin
            if (rxq.size() == 0) chk(1'b0, "R8 rx unexpected data", rx_dout, 0);
            else begin
                logic [7:0] e;
                e = rxq.pop_front();
                chk(rx_dout == e, "R8 rx order", rx_dout, e);
            end
        end
        if (rst_n && tx_pop && tx_count != 0) begin
            if (txq.size() == 0) chk(1'b0, "R8 tx unexpected data", tx_dout, 0);
            else begin
                logic [7:0] e;
                e = txq.pop_front();
                chk(tx_dout == e, "R8 tx order", tx_dout, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(rx_count == 0 && tx_count == 0, "R1 counts", rx_count, 0);
        chk(!rx_irq && !fifo_mode && !aux_mode, "R1 flags", {rx_irq, fifo_mode, aux_mode}, 0);
        chk(host_rdata == 8'h01, "R1 rdata", host_rdata, 8'h01);

        // R9 single-byte holding with queueing off
        push_rx(8'hA1, 1);
        chk(rx_count == 1 && rx_irq, "R9 one byte irq", {rx_irq, rx_count}, 6'h21);
        push_rx(8'hA2, 0);
        chk(rx_count == 1, "R9 capacity one", rx_count, 1);
        chk(rx_err, "R8 push full sets err", rx_err, 1);
        pop_rx();
        chk(rx_count == 0 && !rx_irq, "R9 popped", rx_count, 0);
        wr(8'hC0);
        push_rx(8'hB0, 1);
        chk(rx_irq, "R9 threshold code ignored", rx_irq, 1);
        pop_rx();

        // R3 / R10 threshold 4
        wr(8'h41); tick();
        chk(fifo_mode && host_rdata == 8'hC1, "R10 mode on idle", host_rdata, 8'hC1);
        for (int i = 0; i < 3; i++) push_rx(8'h10 + 8'(i), 1);
        chk(!rx_irq, "R3 below 4", rx_count, 3);
        push_rx(8'h13, 1);
        chk(rx_irq && host_rdata == 8'hC4, "R3 R10 at 4", host_rdata, 8'hC4);

        // R6 same enable value keeps data; R3 threshold 8
        wr(8'h81); tick();
        chk(rx_count == 4, "R6 no flush on same value", rx_count, 4);
        chk(!rx_irq, "R3 below 8", rx_irq, 0);
        for (int i = 0; i < 4; i++) push_rx(8'h20 + 8'(i), 1);
        chk(rx_irq, "R3 at 8", rx_count, 8);

        // R3 threshold 14 and R8 depth
        wr(8'hC1);
        chk(!rx_irq, "R3 below 14", rx_count, 8);
        for (int i = 0; i < 5; i++) push_rx(8'h30 + 8'(i), 1);
        chk(!rx_irq, "R3 at 13", rx_count, 13);
        push_rx(8'h35, 1);
        chk(rx_irq, "R3 at 14", rx_count, 14);
        push_rx(8'h36, 1); push_rx(8'h37, 1);
        push_rx(8'hFF, 0);
        chk(rx_count == 16, "R8 full ignores push", rx_count, 16);
        for (int i = 0; i < 16; i++) pop_rx();
        chk(rx_count == 0, "R8 drained", rx_count, 0);
        pop_rx();
        chk(rx_count == 0 && rx_err, "R8 pop empty ignored", rx_count, 0);

        // R5 receive flush, R11 push during flush discarded
        for (int i = 0; i < 3; i++) push_rx(8'h40 + 8'(i), 1);
        push_tx(8'h50, 1); push_tx(8'h51, 1);
        wr(8'hC3);
        push_rx(8'hEE, 0);
        rxq.delete();
        chk(rx_count == 0, "R5 R11 rx flushed", rx_count, 0);
        chk(tx_count == 2, "R5 tx untouched", tx_count, 2);
        push_rx(8'h5A, 1);
        chk(rx_count == 1, "R5 self-clear", rx_count, 1);

        // R4 transmit flush
        wr(8'hC5); tick();
        txq.delete();
        chk(tx_count == 0 && rx_count == 1, "R4 tx flushed", tx_count, 0);
        push_tx(8'h77, 1);
        chk(tx_count == 1, "R4 self-clear", tx_count, 1);
        pop_tx();
        chk(!tx_err, "R8 tx err clear", tx_err, 0);

        // R7 bit 3 stored, bits 5:4 ignored
        wr(8'hF9); tick();
        chk(aux_mode && fifo_mode, "R7 aux stored", {aux_mode, fifo_mode}, 3);
        chk(rx_count == 1 && host_rdata == 8'hC1, "R7 no side effect", host_rdata, 8'hC1);

        // R2 other address ignored; R10 other address reads zero
        wr_at(3'd0, 8'h00); tick();
        chk(fifo_mode && aux_mode, "R2 other addr write", {aux_mode, fifo_mode}, 3);
        host_addr = 3'd0; #1;
        chk(host_rdata == 8'h00, "R10 other addr read", host_rdata, 0);
        host_addr = 3'd2;

        // R6 disabling flushes both
        push_tx(8'h61, 1);
        wr(8'h00); tick();
        rxq.delete(); txq.delete();
        chk(rx_count == 0 && tx_count == 0, "R6 disable flushes", {rx_count, tx_count}, 0);
        chk(host_rdata == 8'h01, "R10 mode off", host_rdata, 8'h01);

        // R8 transmit depth and overflow
        wr(8'h01); tick();
        for (int i = 0; i < 16; i++) push_tx(8'h80 + 8'(i), 1);
        push_tx(8'hFE, 0);
        chk(tx_count == 16 && tx_err, "R8 tx overflow", tx_count, 16);
        pop_tx(); pop_tx();
        chk(tx_count == 14, "R8 tx pops", tx_count, 14);

        // R12 power wake
        wr(8'h09);
        pwr_wake = 1'b1; tick(); pwr_wake = 1'b0;
        chk(!fifo_mode && !aux_mode, "R12 fields cleared", {aux_mode, fifo_mode}, 0);
        tick();
        txq.delete();
        chk(tx_count == 0, "R12 flushed", tx_count, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule